// File: doc/BRIEF.md
# Multichannel Input Select and Format Stage

This block is the sample front end of a four-channel digital downconverter. Each channel has its own configuration register. The register sets four things: which parallel input bus feeds the channel (one of four 16-bit buses, or a shared test register written by the processor), how the input word is coded, whether the word is a mantissa/exponent pair to be expanded to fixed point, and the delay used to pick one sample out of a time-multiplexed stream.

A one-clock strobe per channel marks the first slot of each multiplexed set. The channel captures the sample a programmed number of clocks after the strobe. It holds that sample and presents it just after the next strobe, so every channel delivers its sample with the same alignment to its strobe.

Configuration arrives over a simple address/data write port. The top nibble of the address picks a channel, or all channels at once. The outputs are valid-only streams, because the downstream oscillator and filter accept one update every clock. A sample-update flag and a filter-update flag qualify each sample. There is no back-pressure: an asserted update is consumed in that cycle, and nothing stalls the strobe cadence.

Top module: `dsel_front`

## Requirements
- R1: A write with address bits 11:0 all zero loads data bits 15:3 into a channel register. Address bits 15:12 select the target: 0 to NCH-1 picks one channel, and F loads every channel in the same cycle. Any other nibble value, or any nonzero value in address bits 11:0, changes no channel register.
- R2: Configuration bits 15:13 pick the channel source: 000 is bus A, 001 bus B, 010 bus C, 011 bus D and 100 the test register. Codes 101 to 111 feed zero.
- R3: A write to address TEST_ADDR (default E000h) loads the test register. When configuration bit 12 is 0, the test source carries the register value only in the cycle after that write, and carries zero otherwise. When bit 12 is 1, bit 11 acts as an active-low enable: 0 passes the register value continuously, and 1 feeds zero.
- R4: When configuration bit 10 is 1, the input is taken as offset binary and its MSB is inverted. When bit 10 is 0, the word passes unchanged as two's complement.
- R5: When configuration bit 9 is 1, the word is expanded as follows. Bits 8:7 give the mantissa field: 00 means bits 15:5, 01 means 15:4, 10 means 15:3 and 11 means 15:2. The exponent is bits 1:0 for split 11 and bits 2:0 otherwise. The result is the sign-extended mantissa times 2 to the power of the exponent, saturated to the range -32768 to 32767.
- R6: Configuration bits 6:4 give a delay d from 0 to 7. The channel captures the formatted sample present d clocks after the clock in which its strobe is high; d = 0 means the strobe clock itself.
- R7: In the clock after a strobe, the sample update flag is high and the sample output carries the value captured in the previous strobe period (zero after reset). In every other clock the flag is low.
- R8: Gated mode (configuration bit 3 = 0): the filter update flag equals the sample update flag, and the sample output holds its value between updates.
- R9: Interpolated mode (bit 3 = 1): the filter update flag is high in every clock. The sample output is zero in every clock without an update. A sample present while the strobe is high is captured as zero.
- R10: Synchronous active-high reset clears every channel register to zero, which selects bus A, two's complement, fixed point, delay 0 and gated mode. Reset also clears the test register and the held samples, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 16 | Write address: channel nibble in 15:12 |
| wr_data_i | input | 16 | Write data |
| bus_a_i | input | DW | Parallel input bus A |
| bus_b_i | input | DW | Parallel input bus B |
| bus_c_i | input | DW | Parallel input bus C |
| bus_d_i | input | DW | Parallel input bus D |
| strobe_i | input | NCH | Per-channel one-clock start-of-set strobe |
| samp_o | output | NCH*DW | Per-channel aligned sample, channel i at bits i*DW+DW-1 : i*DW |
| nco_upd_o | output | NCH | Per-channel sample update (valid) flag |
| cic_upd_o | output | NCH | Per-channel filter update flag |

## Verification
The bench builds the block with its defaults: NCH = 4, DW = 16 and TEST_ADDR = E000h. Four channels leave address nibbles 4 to E free, so ignored writes can be tried next to the broadcast nibble. The 3-bit delay field allows capture at both ends of the 0 to 7 range. With a 16-bit word, each of the four mantissa splits can be pushed into positive and negative saturation. A scoreboard predicts each captured sample from the configuration and the bus words it drove, then compares that prediction against the sample presented after the next strobe.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
  localparam int CFG_W = 16;
  localparam int NIB_W = 4;
  localparam int SRC_W = 3;
  localparam int DLY_W = 3;
  localparam logic [NIB_W-1:0] NIB_ALL = 4'hF;

  typedef enum logic [SRC_W-1:0] {
    SRC_A   = 3'd0,
    SRC_B   = 3'd1,
    SRC_C   = 3'd2,
    SRC_D   = 3'd3,
    SRC_TST = 3'd4
  } src_e;

  // Stored channel setting: upper 13 bits of the written word
  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             tst_hold;
    logic             tst_off;
    logic             offs_bin;
    logic             flt;
    logic [1:0]       split;
    logic [DLY_W-1:0] dly;
    logic             interp;
  } chan_cfg_t;

  localparam int CFG_KEEP = $bits(chan_cfg_t);
endpackage

// File: rtl/dsel_cfg_bank.sv
module dsel_cfg_bank
  import dsel_pkg::*;
#(
  parameter int               NCH       = 4,
  parameter int               DW        = 16,
  parameter logic [CFG_W-1:0] TEST_ADDR = 16'hE000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output chan_cfg_t        cfg_o [NCH],
  output logic [DW-1:0]    tst_val_o,
  output logic             tst_pulse_o
);
  localparam int SUB_W = CFG_W - NIB_W;

  logic [NIB_W-1:0] nib;
  logic             sub_zero;

  assign nib      = wr_addr_i[CFG_W-1 -: NIB_W];
  assign sub_zero = (wr_addr_i[SUB_W-1:0] == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit;
    assign hit = wr_en_i && sub_zero && ((nib == NIB_W'(i)) || (nib == NIB_ALL));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cfg_o[i] <= '0;
      end else if (hit) begin
        cfg_o[i] <= chan_cfg_t'(wr_data_i[CFG_W-1 -: CFG_KEEP]);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tst_val_o   <= '0;
      tst_pulse_o <= 1'b0;
    end else begin
      tst_pulse_o <= wr_en_i && (wr_addr_i == TEST_ADDR);
      if (wr_en_i && (wr_addr_i == TEST_ADDR)) begin
        tst_val_o <= DW'(wr_data_i);
      end
    end
  end
endmodule

// File: rtl/dsel_fmt.sv
module dsel_fmt
  import dsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic             tst_hold_i,
  input  logic             tst_off_i,
  input  logic             offs_bin_i,
  input  logic             flt_i,
  input  logic [1:0]       split_i,
  input  logic [DW-1:0]    bus_a_i,
  input  logic [DW-1:0]    bus_b_i,
  input  logic [DW-1:0]    bus_c_i,
  input  logic [DW-1:0]    bus_d_i,
  input  logic [DW-1:0]    tst_val_i,
  input  logic             tst_pulse_i,
  output logic [DW-1:0]    val_o
);
  localparam int EXT = 8;
  localparam int WW  = DW + EXT;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic              tst_en;
  logic [DW-1:0]     raw;
  logic [DW-1:0]     fixd;
  logic [2:0]        cut;
  logic signed [DW-1:0] mant;
  logic [2:0]        ex;
  logic [WW-1:0]     wide;
  logic              in_range;
  logic [DW-1:0]     sat;

  assign tst_en = tst_hold_i ? ~tst_off_i : tst_pulse_i;

  always_comb begin
    case (src_i)
      SRC_A:   raw = bus_a_i;
      SRC_B:   raw = bus_b_i;
      SRC_C:   raw = bus_c_i;
      SRC_D:   raw = bus_d_i;
      SRC_TST: raw = tst_en ? tst_val_i : '0;
      default: raw = '0;
    endcase
  end

  assign fixd = offs_bin_i ? {~raw[DW-1], raw[DW-2:0]} : raw;

  // Mantissa is the upper field; drop the low bits arithmetically
  assign cut  = 3'd5 - {1'b0, split_i};
  assign mant = $signed(fixd) >>> cut;
  assign ex   = (split_i == 2'b11) ? {1'b0, fixd[1:0]} : fixd[2:0];
  assign wide = {{EXT{mant[DW-1]}}, mant} << ex;

  assign in_range = (wide[WW-1:DW-1] == '0) || (wide[WW-1:DW-1] == '1);
  assign sat      = in_range ? wide[DW-1:0] : (wide[WW-1] ? MINV : MAXV);

  assign val_o = flt_i ? sat : fixd;
endmodule

// File: rtl/dsel_demux.sv
module dsel_demux
  import dsel_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             strobe_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             interp_i,
  input  logic [DW-1:0]    val_i,
  output logic [DW-1:0]    samp_o,
  output logic             nco_upd_o,
  output logic             cic_upd_o
);
  logic [DLY_W-1:0] cnt;
  logic             active;
  logic             take;
  logic [DW-1:0]    in_val;
  logic [DW-1:0]    hold;

  assign take   = (strobe_i && (dly_i == '0)) || (active && (cnt == dly_i));
  assign in_val = (interp_i && strobe_i) ? '0 : val_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (strobe_i) begin
      cnt    <= DLY_W'(1);
      active <= (dly_i != '0);
    end else if (active) begin
      if (cnt == dly_i) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt + DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold      <= '0;
      samp_o    <= '0;
      nco_upd_o <= 1'b0;
      cic_upd_o <= 1'b0;
    end else begin
      if (take) begin
        hold <= in_val;
      end
      nco_upd_o <= strobe_i;
      cic_upd_o <= strobe_i | interp_i;
      if (strobe_i) begin
        samp_o <= hold;
      end else if (interp_i) begin
        samp_o <= '0;
      end
    end
  end
endmodule

// File: rtl/dsel_front.sv
module dsel_front
  import dsel_pkg::*;
#(
  parameter int               NCH       = 4,
  parameter int               DW        = 16,
  parameter logic [CFG_W-1:0] TEST_ADDR = 16'hE000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [CFG_W-1:0]  wr_addr_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic [DW-1:0]     bus_a_i,
  input  logic [DW-1:0]     bus_b_i,
  input  logic [DW-1:0]     bus_c_i,
  input  logic [DW-1:0]     bus_d_i,
  input  logic [NCH-1:0]    strobe_i,
  output logic [NCH*DW-1:0] samp_o,
  output logic [NCH-1:0]    nco_upd_o,
  output logic [NCH-1:0]    cic_upd_o
);
  chan_cfg_t       cfg_w [NCH];
  logic [DW-1:0]   tst_val;
  logic            tst_pulse;
  logic [NCH-1:0]  interp_vec;

  dsel_cfg_bank #(
    .NCH(NCH), .DW(DW), .TEST_ADDR(TEST_ADDR)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cfg_o      (cfg_w),
    .tst_val_o  (tst_val),
    .tst_pulse_o(tst_pulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] fmt_val;

    assign interp_vec[i] = cfg_w[i].interp;

    dsel_fmt #(.DW(DW)) u_fmt (
      .src_i      (cfg_w[i].src),
      .tst_hold_i (cfg_w[i].tst_hold),
      .tst_off_i  (cfg_w[i].tst_off),
      .offs_bin_i (cfg_w[i].offs_bin),
      .flt_i      (cfg_w[i].flt),
      .split_i    (cfg_w[i].split),
      .bus_a_i    (bus_a_i),
      .bus_b_i    (bus_b_i),
      .bus_c_i    (bus_c_i),
      .bus_d_i    (bus_d_i),
      .tst_val_i  (tst_val),
      .tst_pulse_i(tst_pulse),
      .val_o      (fmt_val)
    );

    dsel_demux #(.DW(DW)) u_dmx (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .strobe_i  (strobe_i[i]),
      .dly_i     (cfg_w[i].dly),
      .interp_i  (cfg_w[i].interp),
      .val_i     (fmt_val),
      .samp_o    (samp_o[i*DW +: DW]),
      .nco_upd_o (nco_upd_o[i]),
      .cic_upd_o (cic_upd_o[i])
    );
  end
endmodule

// File: rtl/dsel_front_chk.sv
module dsel_front_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [NCH-1:0]    strobe_i,
  input logic [NCH*DW-1:0] samp_o,
  input logic [NCH-1:0]    nco_upd_o,
  input logic [NCH-1:0]    cic_upd_o,
  input logic [NCH-1:0]    interp_vec
);
  logic was_rst = 1'b0;

  always_ff @(posedge clk_i) begin
    was_rst <= rst_i;
    if (was_rst) begin
      // r10: outputs cleared after a reset clock
      a_reset_clear_r10: assert (samp_o == '0 && nco_upd_o == '0 && cic_upd_o == '0);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_upd_after_strobe_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_i[i] |=> nco_upd_o[i]);

    p_upd_only_after_strobe_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_i[i] |=> !nco_upd_o[i]);

    p_gated_cic_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !interp_vec[i] |=> (cic_upd_o[i] == nco_upd_o[i]));

    p_gated_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!interp_vec[i] && !strobe_i[i]) |=> $stable(samp_o[i*DW +: DW]));

    p_interp_cic_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      interp_vec[i] |=> cic_upd_o[i]);

    p_interp_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (interp_vec[i] && !strobe_i[i]) |=> (samp_o[i*DW +: DW] == '0));
  end
endmodule

bind dsel_front dsel_front_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .strobe_i   (strobe_i),
  .samp_o     (samp_o),
  .nco_upd_o  (nco_upd_o),
  .cic_upd_o  (cic_upd_o),
  .interp_vec (interp_vec)
);

// File: tb/dsel_front_tb_top.sv
`timescale 1ns/1ps
module dsel_front_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam logic [15:0] TST = 16'hE000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [DW-1:0] bus_a = '0, bus_b = '0, bus_c = '0, bus_d = '0;
  logic [NCH-1:0] strobe = '0;
  logic [NCH*DW-1:0] samp;
  logic [NCH-1:0] nco_upd, cic_upd;

  always #10 clk = ~clk;

  dsel_front #(.NCH(NCH), .DW(DW), .TEST_ADDR(TST)) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .bus_a_i(bus_a), .bus_b_i(bus_b), .bus_c_i(bus_c), .bus_d_i(bus_d),
    .strobe_i(strobe), .samp_o(samp), .nco_upd_o(nco_upd), .cic_upd_o(cic_upd)
  );

  int errs = 0, checks = 0;
  bit done = 0, started = 0;
  logic [15:0] cfg_m [NCH];
  logic        mon_interp [NCH];
  logic [15:0] hold_m [NCH];
  string       hold_tag [NCH];
  logic [15:0] prev [NCH];
  logic [15:0] tst_m = '0;
  bit          pulse_m = 0;
  int          qch[$];
  logic [15:0] qv[$];
  string       qtag[$];

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(int src, bit hold, bit off, bit ob, bit flt,
                                     int split, int dly, bit interp);
    logic [15:0] w;
    w = {src[2:0], hold, off, ob, flt, split[1:0], dly[2:0], interp, 3'b000};
    return w;
  endfunction

  // Reference model built from the requirements
  function automatic logic [15:0] model(logic [15:0] c, logic [15:0] a, logic [15:0] b,
                                        logic [15:0] cc, logic [15:0] d, logic [15:0] t,
                                        bit pulse, bit strb);
    logic [15:0] x;
    bit en;
    int sv, m, e, r, k;
    en = c[12] ? !c[11] : pulse;
    case (c[15:13])
      3'd0: x = a;
      3'd1: x = b;
      3'd2: x = cc;
      3'd3: x = d;
      3'd4: x = en ? t : 16'h0000;
      default: x = 16'h0000;
    endcase
    if (c[10]) x = x ^ 16'h8000;
    if (c[9]) begin
      k  = int'(c[8:7]);
      sv = int'($signed(x));
      m  = sv >>> (5 - k);
      e  = (k == 3) ? int'(x[1:0]) : int'(x[2:0]);
      r  = m * (1 << e);
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      x = r[15:0];
    end
    if (c[3] && strb) x = 16'h0000;
    return x;
  endfunction

  function automatic logic [15:0] word(int base, int step, int k, int bus);
    int t;
    t = base + step * k + bus * 961;
    return t[15:0];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    qch.delete(); qv.delete(); qtag.delete();
    for (int c = 0; c < NCH; c++) begin
      cfg_m[c] = '0; mon_interp[c] = 1'b0; hold_m[c] = '0; hold_tag[c] = "R10";
    end
    tst_m = '0; pulse_m = 0;
    repeat (3) @(negedge clk);
    chk(samp == '0, "R10", samp[15:0], 16'h0, "samp after reset");
    chk(nco_upd == '0, "R10", 16'(nco_upd), 16'h0, "sample update after reset");
    chk(cic_upd == '0, "R10", 16'(cic_upd), 16'h0, "filter update after reset");
    rst = 1'b0;
    started = 1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(logic [15:0] addr, logic [15:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr[11:0] == 12'h000) begin
      for (int c = 0; c < NCH; c++)
        if (addr[15:12] == 4'(c) || addr[15:12] == 4'hF) cfg_m[c] = data;
    end
    for (int c = 0; c < NCH; c++) mon_interp[c] = cfg_m[c][3];
    @(negedge clk);
  endtask

  task automatic wr_tst(logic [15:0] data);
    wr_en = 1'b1; wr_addr = TST; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    tst_m = data;
    pulse_m = 1;
  endtask

  task automatic frame(int ch, int per, int base, int step, string tag);
    int d;
    logic [15:0] cap;
    d = int'(cfg_m[ch][6:4]);
    cap = hold_m[ch];
    for (int k = 0; k < per; k++) begin
      strobe = (k == 0) ? NCH'(1 << ch) : '0;
      bus_a = word(base, step, k, 0);
      bus_b = word(base, step, k, 1);
      bus_c = word(base, step, k, 2);
      bus_d = word(base, step, k, 3);
      if (k == 0) begin
        qch.push_back(ch); qv.push_back(hold_m[ch]); qtag.push_back(hold_tag[ch]);
      end
      if (k == d) cap = model(cfg_m[ch], bus_a, bus_b, bus_c, bus_d, tst_m, pulse_m, k == 0);
      @(negedge clk);
      pulse_m = 0;
    end
    strobe = '0;
    hold_m[ch] = cap;
    hold_tag[ch] = tag;
  endtask

  // Monitor: pops expected samples on each update and checks mode behaviour
  logic [15:0] s_mon;
  always @(posedge clk) begin
    #5;
    if (rst) begin
      for (int c = 0; c < NCH; c++) prev[c] = '0;
    end else if (started) begin
      for (int c = 0; c < NCH; c++) begin
        s_mon = samp[c*DW +: DW];
        if (nco_upd[c]) begin
          if (qv.size() == 0) begin
            chk(0, "R7", s_mon, 16'h0, "update with no pending sample");
          end else begin
            chk(qch[0] == c && s_mon == qv[0], qtag[0], s_mon, qv[0], "aligned sample");
            void'(qch.pop_front()); void'(qv.pop_front()); void'(qtag.pop_front());
          end
        end else if (mon_interp[c]) begin
          chk(s_mon == 16'h0, "R9", s_mon, 16'h0, "zero stuffing");
        end else begin
          chk(s_mon == prev[c], "R8", s_mon, prev[c], "hold between updates");
        end
        if (mon_interp[c])
          chk(cic_upd[c] == 1'b1, "R9", 16'(cic_upd[c]), 16'h1, "filter update every clock");
        else
          chk(cic_upd[c] == nco_upd[c], "R8", 16'(cic_upd[c]), 16'(nco_upd[c]), "gated filter update");
        prev[c] = s_mon;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Default setting: bus A, delay 0, gated
    frame(0, 4, 16'h1000, 16'h0111, "R6");
    frame(0, 4, 16'h2000, 16'h0123, "R6");

    // Source and delay choices
    wr_cfg(16'h0000, cw(1, 0, 0, 0, 0, 0, 3, 0));
    frame(0, 5, 16'h2345, 16'h0101, "R2");
    frame(0, 5, 16'h3456, 16'h0202, "R2");
    wr_cfg(16'h0000, cw(2, 0, 0, 1, 0, 0, 7, 0));
    frame(0, 8, 16'h0F00, 16'h1111, "R4");
    frame(0, 8, 16'hF0F0, 16'h0321, "R4");
    wr_cfg(16'h0000, cw(3, 0, 0, 0, 0, 0, 5, 0));
    frame(0, 7, 16'hA000, 16'h0707, "R6");
    frame(0, 7, 16'h5000, 16'h0909, "R6");
    wr_cfg(16'h0000, cw(5, 0, 0, 0, 0, 0, 0, 0));
    frame(0, 3, 16'h1234, 16'h0001, "R2");
    frame(0, 3, 16'h4321, 16'h0001, "R2");

    // Floating-point expansion, each split, with saturation
    for (int sp = 0; sp < 4; sp++) begin
      wr_cfg(16'h0000, cw(0, 0, 0, 0, 1, sp, 1, 0));
      frame(0, 3, 16'h0123 + sp * 16'h1111, 16'h0F0F, "R5");
      frame(0, 3, 16'h7FE7, 0, "R5");
      frame(0, 3, 16'h8007, 0, "R5");
      frame(0, 3, 16'h0042, 16'h0003, "R5");
    end
    wr_cfg(16'h0000, cw(0, 0, 0, 1, 1, 2, 0, 0));
    frame(0, 3, 16'h7FF9, 16'h0010, "R5");
    frame(0, 3, 16'h0002, 16'h0010, "R5");

    // Interpolated mode
    wr_cfg(16'h0000, cw(1, 0, 0, 0, 0, 0, 0, 1));
    frame(0, 4, 16'h6666, 16'h0011, "R9");
    wr_cfg(16'h0000, cw(1, 0, 0, 0, 0, 0, 2, 1));
    frame(0, 4, 16'h7777, 16'h0011, "R9");
    frame(0, 4, 16'h1357, 16'h0011, "R9");
    frame(0, 4, 16'h2468, 16'h0011, "R9");

    // Test register: static enable, static disable, one-shot
    wr_cfg(16'h0000, cw(4, 1, 0, 0, 0, 0, 2, 0));
    wr_tst(16'h1357);
    frame(0, 4, 16'h0000, 16'h0001, "R3");
    frame(0, 4, 16'h0000, 16'h0001, "R3");
    wr_cfg(16'h0000, cw(4, 1, 1, 0, 0, 0, 2, 0));
    frame(0, 4, 16'h0000, 16'h0001, "R3");
    frame(0, 4, 16'h0000, 16'h0001, "R3");
    wr_cfg(16'h0000, cw(4, 0, 0, 0, 0, 0, 0, 0));
    wr_tst(16'h2468);
    frame(0, 3, 16'h0000, 16'h0001, "R3");
    frame(0, 3, 16'h0000, 16'h0001, "R3");
    wr_cfg(16'h0000, cw(4, 0, 0, 0, 0, 0, 1, 0));
    wr_tst(16'h0BAD);
    frame(0, 3, 16'h0000, 16'h0001, "R3");
    frame(0, 3, 16'h0000, 16'h0001, "R3");

    // Broadcast and ignored writes
    wr_cfg(16'hF000, cw(2, 0, 0, 0, 0, 0, 4, 0));
    frame(3, 6, 16'h3030, 16'h0303, "R1");
    frame(1, 6, 16'h1010, 16'h0101, "R1");
    frame(0, 6, 16'h0A0A, 16'h0505, "R1");
    wr_cfg(16'h7000, cw(1, 0, 0, 0, 0, 0, 0, 1));
    wr_cfg(16'h2010, cw(3, 0, 0, 0, 0, 0, 1, 0));
    frame(2, 6, 16'h2020, 16'h0202, "R1");
    frame(2, 6, 16'h2121, 16'h0202, "R1");
    wr_cfg(16'h2000, cw(0, 0, 0, 0, 0, 0, 6, 1));
    frame(2, 7, 16'h4040, 16'h0404, "R1");
    frame(2, 7, 16'h4141, 16'h0404, "R1");
    frame(3, 6, 16'h3131, 16'h0303, "R1");

    // Reset clears channel settings and held samples
    wr_cfg(16'h1000, cw(1, 0, 0, 0, 0, 0, 1, 1));
    frame(1, 3, 16'h5151, 16'h0101, "R9");
    do_reset();
    frame(1, 3, 16'h6161, 16'h0101, "R10");
    frame(1, 3, 16'h7171, 16'h0101, "R10");

    repeat (4) @(negedge clk);
    chk(qv.size() == 0, "R7", 16'(qv.size()), 16'h0, "pending samples left");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule